// File: doc/BRIEF.md
# Eight-Entry Frame Queue with Wrapping Level Status

This block is a synchronous first-in first-out queue for 9-bit serial-bus frames, eight slots deep. A serial controller places two copies of it, one on the send path and one on the receive path. The producer offers a frame with `push` and the consumer removes the oldest one with `pop`. The oldest frame is always visible on `pop_data` while the queue holds data. Both operations are honoured only while `en` is high.

The occupancy is reported on a three-bit `level` field, so it can only count from 0 to 7. With all eight slots in use, the field wraps to 0, and the consumer must look at `full` to tell a full queue from an empty one. A `half` flag marks four or more stored frames.

A soft-reset request `soft_rst` returns an empty queue's pointers to slot zero in a single cycle. If the request arrives while frames are still stored, the queue keeps its contents and raises a one-cycle `busy_err` instead. Software must therefore drain the receive copy before it resets the controller.

Top module: `frame_queue`

## Requirements
- R1: After `rst_n` is released, `level` is 0 and `full`, `half` and `busy_err` are 0.
- R2: Frames leave in the order they were accepted, and while one or more frames are stored, `pop_data` shows the oldest of them.
- R3: `level` equals the number of stored frames modulo 8. With 8 frames stored, `level` reads 0 and `full` is 1; with fewer frames, `full` is 0.
- R4: `half` is 1 exactly when 4 or more frames are stored.
- R5: A push while 8 frames are stored, with no pop in the same cycle, is ignored: the count and the stored frames are unchanged.
- R6: A pop while the queue is empty is ignored: the queue stays empty.
- R7: While `en` is 0, `push` and `pop` have no effect on the count or on the stored frames.
- R8: `soft_rst` on an empty queue leaves it empty, raises no `busy_err`, and later pushes and pops work normally.
- R9: `soft_rst` while one or more frames are stored drives `busy_err` to 1 for exactly the following cycle, and the stored frames and the count are kept.
- R10: In a cycle with `soft_rst` high, `push` and `pop` are ignored.
- R11: A push together with a pop, on a queue that is neither empty nor full, leaves the count unchanged and appends the new frame behind the remaining ones. On a full queue, only the pop takes effect. On an empty queue, only the push takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Queue enable; push and pop act only while high |
| soft_rst | input | 1 | Soft-reset request: flushes the pointers when the queue is empty, flags an error otherwise |
| push | input | 1 | Store `push_data` this cycle |
| push_data | input | 9 | Frame to store |
| pop | input | 1 | Remove the oldest frame this cycle |
| pop_data | output | 9 | Oldest stored frame |
| level | output | 3 | Stored frame count modulo 8 |
| half | output | 1 | Four or more frames stored |
| full | output | 1 | Eight frames stored |
| busy_err | output | 1 | One-cycle pulse: soft reset was requested with frames stored |

## Verification
The directed part first fills the queue to eight. This separates the wrapped `level` of 0 from a truly empty queue, because only `full` differs between them. It then pushes into the full queue and pops from the empty one to show that those requests are dropped. Soft reset is applied once on an empty queue and once on a loaded queue; the second case must give the error pulse and keep the data, while the first gives neither. Long random runs with a high push or pop bias, occasional disabled cycles and rare soft resets then sweep every occupancy and the simultaneous push-and-pop cases. Each popped frame is compared with a reference queue, which exposes any reordering or pointer slip.

// File: rtl/fq_pkg.sv
package fq_pkg;
   localparam int FQ_FRAME_W = 9;
   localparam int FQ_DEPTH   = 8;

   function automatic bit fq_is_pow2(input int n);
      return (n > 1) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/fq_ctrl.sv
module fq_ctrl #(
   parameter int DEPTH = 8,
   parameter int PTR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             soft_rst,
   input  logic             push,
   input  logic             pop,
   output logic             wr_ok,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [PTR_W:0]   count,
   output logic             busy_err
);
   localparam int CNT_W = PTR_W + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

   logic rd_ok;
   logic flush;
   logic not_empty;

   assign not_empty = (count != '0);
   assign wr_ok     = en & ~soft_rst & push & (count != CNT_MAX);
   assign rd_ok     = en & ~soft_rst & pop & not_empty;
   assign flush     = soft_rst & ~not_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         count    <= '0;
         busy_err <= 1'b0;
      end else begin
         busy_err <= soft_rst & not_empty;
         if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
         end else begin
            if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
            count <= count + CNT_W'(wr_ok) - CNT_W'(rd_ok);
         end
      end
   end
endmodule

// File: rtl/fq_store.sv
module fq_store #(
   parameter int DATA_W      = 9,
   parameter int DEPTH       = 8,
   parameter int PTR_W       = 3,
   parameter bit RESET_SLOTS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_ptr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [PTR_W-1:0]  rd_ptr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] slot [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [DATA_W-1:0] q;
      logic              hit;
      assign hit     = wr_en && (wr_ptr == PTR_W'(i));
      assign slot[i] = q;
      if (RESET_SLOTS) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wr_data;
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (hit) q <= wr_data;
         end
      end
   end

   assign rd_data = slot[rd_ptr];
endmodule

// File: rtl/fq_flags.sv
module fq_flags #(
   parameter int PTR_W     = 3,
   parameter int HALF_MARK = 4
) (
   input  logic [PTR_W:0]   count,
   output logic [PTR_W-1:0] level,
   output logic             half,
   output logic             full
);
   assign level = count[PTR_W-1:0];
   assign full  = count[PTR_W];
   assign half  = (count >= (PTR_W+1)'(HALF_MARK));
endmodule

// File: rtl/frame_queue.sv
module frame_queue #(
   parameter int DATA_W      = fq_pkg::FQ_FRAME_W,
   parameter int DEPTH       = fq_pkg::FQ_DEPTH,
   parameter int HALF_MARK   = DEPTH / 2,
   parameter bit RESET_SLOTS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              soft_rst,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] pop_data,
   output logic [$clog2(DEPTH)-1:0] level,
   output logic              half,
   output logic              full,
   output logic              busy_err
);
   localparam int PTR_W = $clog2(DEPTH);

   if (!fq_pkg::fq_is_pow2(DEPTH)) begin : g_bad_depth
      $error("frame_queue: DEPTH must be a power of two above 1");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("frame_queue: DATA_W must be at least 1");
   end
   if (HALF_MARK < 1 || HALF_MARK > DEPTH) begin : g_bad_mark
      $error("frame_queue: HALF_MARK out of range");
   end

   logic             wr_ok;
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic [PTR_W:0]   count;

   fq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .en(en), .soft_rst(soft_rst),
      .push(push), .pop(pop), .wr_ok(wr_ok), .wr_ptr(wr_ptr),
      .rd_ptr(rd_ptr), .count(count), .busy_err(busy_err)
   );

   fq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W),
              .RESET_SLOTS(RESET_SLOTS)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .wr_ptr(wr_ptr),
      .wr_data(push_data), .rd_ptr(rd_ptr), .rd_data(pop_data)
   );

   fq_flags #(.PTR_W(PTR_W), .HALF_MARK(HALF_MARK)) u_flags (
      .count(count), .level(level), .half(half), .full(full)
   );
endmodule

// File: rtl/frame_queue_chk.sv
module frame_queue_chk #(
   parameter int PTR_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             soft_rst,
   input logic             push,
   input logic             pop,
   input logic [PTR_W-1:0] level,
   input logic             half,
   input logic             full,
   input logic             busy_err
);
   assert_level_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> (level == '0));

   assert_half_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> half);

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && en && !soft_rst) |=> (full && level == '0));

   assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!full && level == '0 && pop && !push) |=> (!full && level == '0));

   assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !soft_rst) |=> ($stable(level) && $stable(full)));

   assert_quiet_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && !full && level == '0) |=> (!busy_err && !full && level == '0));

   assert_busy_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && (full || level != '0)) |=> busy_err);

   assert_srst_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> ($stable(level) && $stable(full)));

   assert_both_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !soft_rst && push && pop && !full && level != '0) |=> $stable(level));
endmodule

bind frame_queue frame_queue_chk #(.PTR_W(PTR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .soft_rst(soft_rst),
   .push(push), .pop(pop), .level(level), .half(half),
   .full(full), .busy_err(busy_err)
);

// File: tb/frame_queue_bench.sv
`timescale 1ns/1ps
module frame_queue_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       soft_rst = 1'b0;
   logic       push = 1'b0;
   logic [8:0] push_data = '0;
   logic       pop = 1'b0;
   logic [8:0] pop_data;
   logic [2:0] level;
   logic       half;
   logic       full;
   logic       busy_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [8:0] mq [8];
   int         mcnt = 0;
   bit         mbusy = 1'b0;

   always #2.5 clk = ~clk;

   frame_queue u_frame_queue (
      .clk(clk), .rst_n(rst_n), .en(en), .soft_rst(soft_rst),
      .push(push), .push_data(push_data), .pop(pop), .pop_data(pop_data),
      .level(level), .half(half), .full(full), .busy_err(busy_err)
   );

   function automatic int exp_level(input int n);
      return n % 8;
   endfunction

   function automatic bit exp_half(input int n);
      return n >= 4;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic check_all();
      check(level == 3'(exp_level(mcnt)), "R3 level", level, exp_level(mcnt));
      check(full == (mcnt == 8), "R3 full", full, int'(mcnt == 8));
      check(half == exp_half(mcnt), "R4 half", half, exp_half(mcnt));
      check(busy_err == mbusy, "R9 busy_err", busy_err, mbusy);
      if (mcnt > 0)
         check(pop_data == mq[0], "R2 head frame", pop_data, mq[0]);
   endtask

   // Apply one cycle of stimulus just after a falling edge, update the model,
   // then check at the next falling edge.
   task automatic cycle(input bit p, input bit q, input bit e, input bit s, input logic [8:0] d);
      push = p; pop = q; en = e; soft_rst = s; push_data = d;
      @(posedge clk);
      mbusy = s && (mcnt != 0);
      if (!s && e) begin
         int old = mcnt;
         bit do_pop = q && (old > 0);
         bit do_push = p && (old < 8);
         if (do_pop) begin
            for (int i = 0; i < 7; i++) mq[i] = mq[i+1];
            mcnt--;
         end
         if (do_push) begin
            mq[mcnt] = d;
            mcnt++;
         end
      end
      @(negedge clk);
      check_all();
   endtask

   initial begin : watchdog
      #900000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(level == 0 && !full && !half && !busy_err, "R1 reset state",
            {level, full, half, busy_err}, 0);

      // R6 pop on empty queue
      cycle(0, 1, 1, 0, 9'h000);
      check(level == 0 && !full, "R6 pop empty ignored", level, 0);

      // Fill to eight: R3 wrap of level with full set
      for (int i = 0; i < 8; i++) cycle(1, 0, 1, 0, 9'(9'h101 + i * 3));
      check(level == 0 && full, "R3 eight stored level wraps", level, 0);

      // R5 push when full
      cycle(1, 0, 1, 0, 9'h1ff);
      check(full && pop_data == 9'h101, "R5 push full ignored", pop_data, 9'h101);

      // R11 push and pop on full: only the pop
      cycle(1, 1, 1, 0, 9'h0aa);
      check(level == 7 && !full, "R11 full push+pop", level, 7);

      // R7 disabled
      cycle(1, 1, 0, 0, 9'h055);
      check(level == 7 && pop_data == 9'h104, "R7 disabled ignored", pop_data, 9'h104);

      // R11 push and pop mid-level
      cycle(1, 1, 1, 0, 9'h0bb);
      check(level == 7, "R11 mid push+pop keeps count", level, 7);

      // R9 soft reset with data: busy pulse, data kept; R10 push ignored
      cycle(1, 0, 1, 1, 9'h0cc);
      check(busy_err && level == 7, "R9 busy pulse data kept", busy_err, 1);
      check(level == 7, "R10 push blocked by soft reset", level, 7);
      cycle(0, 0, 1, 0, 9'h000);
      check(!busy_err, "R9 busy one cycle only", busy_err, 0);

      // Drain, then R8 soft reset on empty
      for (int i = 0; i < 7; i++) cycle(0, 1, 1, 0, 9'h000);
      cycle(0, 0, 1, 1, 9'h000);
      check(!busy_err && level == 0 && !full, "R8 quiet flush", busy_err, 0);
      cycle(1, 0, 1, 0, 9'h123);
      cycle(1, 0, 1, 0, 9'h0de);
      check(pop_data == 9'h123 && level == 2, "R8 works after flush", pop_data, 9'h123);
      cycle(0, 1, 1, 0, 9'h000);
      check(pop_data == 9'h0de, "R2 order after flush", pop_data, 9'h0de);

      // Random phase with phases of fill bias and drain bias
      for (int ph = 0; ph < 12; ph++) begin
         int bias = (ph % 2 == 0) ? 75 : 25;
         for (int n = 0; n < 400; n++) begin
            bit p = ($urandom % 100) < bias;
            bit q = ($urandom % 100) < (100 - bias);
            bit e = ($urandom % 100) < 90;
            bit s = ($urandom % 100) < 2;
            cycle(p, q, e, s, 9'($urandom));
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule